// File: doc/BRIEF.md
# Event Performance Monitor

This block counts processor activity for profiling. It holds one control register, a dedicated 32-bit cycle counter and two 32-bit event counters whose sources are chosen by 8-bit event codes. A single register port reads or writes one of the four registers, selected by a 2-bit index. The event inputs arrive as a vector of one-cycle pulses, indexed by the event code.

There is no way to start or stop one counter on its own. A global run bit gates all three counters. To park an event counter, software points its event select at the external trace-output code (0x20) while that input is held low. The two event counters share one zeroing bit, and the cycle counter has a zeroing bit of its own. Every counter can also be loaded directly with any value. When a counter wraps, it sets a sticky overflow flag, which software clears by writing 1 to it. A single interrupt line is high while any flag is set together with its enable bit.

Top module: `perf_mon`

## Requirements
- R1: After reset, all four registers read 0 and `irqOut` is low.
- R2: The counters change only while control bit 0 (run) is set, unless they are written directly or zeroed. There is no enable for a single counter.
- R3: The cycle counter adds 1 on every clock while run is set. With control bit 3 set, it adds 1 only on every 64th enabled clock. Zeroing the cycle counter also restarts this divide phase.
- R4: Counter A takes its event code from control bits 27:20, and counter B from bits 19:12. A counter adds 1 on a clock when `evtIn[code]` is high. Code 0xFF counts every clock. Codes at or above `EVT_W` never count. Code 0x20 (`evtIn[32]`) does not count while that input is low.
- R5: Writing control with bit 1 set zeroes counters A and B together. Writing control with bit 2 set zeroes the cycle counter. Both bits read back as 0.
- R6: Register index 1 is the cycle counter, 2 is counter A and 3 is counter B. A write loads the value given. If a load and an increment fall on the same clock, the loaded value wins.
- R7: When a counter increments from 0xFFFFFFFF it becomes 0 and sets its overflow flag. The flags are control bit 8 for A, bit 9 for B and bit 10 for the cycle counter.
- R8: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. Writing back a control value that was read leaves every non-flag field as it was. If a clear and a new overflow of the same counter fall on one clock, the flag stays set.
- R9: `irqOut` is high exactly when some flag is set together with its enable. The enables are control bit 4 for A, bit 5 for B and bit 6 for the cycle counter.
- R10: Control bits 7, 11 and 31:28 read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 2 | Register index: 0 control, 1 cycle, 2 counter A, 3 counter B |
| regWr | input | 1 | Write strobe for the selected register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data of the selected register (combinational) |
| evtIn | input | EVT_W | Event pulses, indexed by event code |
| irqOut | output | 1 | Combined overflow interrupt |

## Verification
Two pairs of functions can land on the same clock. A direct counter load can meet an increment of that counter, and a flag-clearing control write can meet a wrap of that counter. The directed part times each collision exactly. It loads 0xFFFFFFFF, then writes the flag clear one clock later, while the event source is active. It then requires the loaded value to win, and the flag and the interrupt to stay up. The random part mixes near-wrap loads, control writes that carry random flag bits, and dense events. Every clock it compares all four registers and the interrupt line with a bench model built from the requirements.

// File: rtl/pm_pkg.sv
package pm_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int CNT_W   = 32;
  localparam int SEL_W   = 8;
  localparam int NUM_CNT = 3;   // 0: counter A, 1: counter B, 2: cycle counter
  localparam int REG_W   = 32;

  localparam logic [SEL_W-1:0] SEL_EVERY_CLK = 8'hFF;

  // control register layout
  localparam int BIT_RUN      = 0;
  localparam int BIT_ZERO_EVT = 1;
  localparam int BIT_ZERO_CYC = 2;
  localparam int BIT_DIV      = 3;
  localparam int IEN_LO       = 4;
  localparam int FLAG_LO      = 8;
  localparam int SELB_LO      = 12;
  localparam int SELA_LO      = 20;

  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_CYC  = 2'd1;
  localparam logic [1:0] IDX_A    = 2'd2;
  localparam logic [1:0] IDX_B    = 2'd3;

  typedef struct packed {
    logic                 runAll;
    logic                 divSlow;
    logic [SEL_W-1:0]     selA;
    logic [SEL_W-1:0]     selB;
    logic                 zeroEvt;
    logic                 zeroCyc;
    logic [NUM_CNT-1:0]   loadCnt;
    logic [CNT_W-1:0]     loadVal;
  } strobe_t;
endpackage

// File: rtl/pm_counter.sv
module pm_counter #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [WIDTH-1:0] loadVal,
  input  logic             zero,
  input  logic             bump,
  output logic [WIDTH-1:0] count,
  output logic             wrap
);
  timeunit 1ns;
  timeprecision 100ps;

  // load beats zero, zero beats increment
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      count <= '0;
    else if (load)  count <= loadVal;
    else if (zero)  count <= '0;
    else if (bump)  count <= count + 1'b1;
  end

  assign wrap = bump && !load && !zero && (count == {WIDTH{1'b1}});

  // R7: a wrap leaves the counter at zero
  p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrap |=> count == '0);

  // R6: a load is always what the counter holds next
  p_write_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    load |=> count == $past(loadVal));
endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pm_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         regSel,
  input  logic               regWr,
  input  logic [REG_W-1:0]   regWdata,
  input  logic [NUM_CNT-1:0] wrapHit,
  output strobe_t            stb,
  output logic [REG_W-1:0]   ctrlRead,
  output logic               irqOut
);
  timeunit 1ns;
  timeprecision 100ps;

  logic               runQ;
  logic               divQ;
  logic [NUM_CNT-1:0] ienQ;
  logic [NUM_CNT-1:0] flagQ;
  logic [SEL_W-1:0]   selAQ;
  logic [SEL_W-1:0]   selBQ;
  logic               ctrlWr;
  logic [NUM_CNT-1:0] clearMask;
  logic               unusedBits;

  assign ctrlWr    = regWr && (regSel == IDX_CTRL);
  assign clearMask = ctrlWr ? regWdata[FLAG_LO +: NUM_CNT] : '0;
  assign unusedBits = ^{regWdata[31:28], regWdata[11], regWdata[7]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      divQ  <= 1'b0;
      ienQ  <= '0;
      flagQ <= '0;
      selAQ <= '0;
      selBQ <= '0;
    end else begin
      // a fresh wrap outranks a clear on the same clock
      flagQ <= (flagQ & ~clearMask) | wrapHit;
      if (ctrlWr) begin
        runQ  <= regWdata[BIT_RUN];
        divQ  <= regWdata[BIT_DIV];
        ienQ  <= regWdata[IEN_LO +: NUM_CNT];
        selAQ <= regWdata[SELA_LO +: SEL_W];
        selBQ <= regWdata[SELB_LO +: SEL_W];
      end
    end
  end

  always_comb begin
    stb.runAll     = runQ;
    stb.divSlow    = divQ;
    stb.selA       = selAQ;
    stb.selB       = selBQ;
    stb.zeroEvt    = ctrlWr && regWdata[BIT_ZERO_EVT];
    stb.zeroCyc    = ctrlWr && regWdata[BIT_ZERO_CYC];
    stb.loadCnt[0] = regWr && (regSel == IDX_A);
    stb.loadCnt[1] = regWr && (regSel == IDX_B);
    stb.loadCnt[2] = regWr && (regSel == IDX_CYC);
    stb.loadVal    = regWdata;
  end

  always_comb begin
    ctrlRead                        = '0;
    ctrlRead[BIT_RUN]               = runQ;
    ctrlRead[BIT_DIV]               = divQ;
    ctrlRead[IEN_LO +: NUM_CNT]     = ienQ;
    ctrlRead[FLAG_LO +: NUM_CNT]    = flagQ;
    ctrlRead[SELB_LO +: SEL_W]      = selBQ;
    ctrlRead[SELA_LO +: SEL_W]      = selAQ;
  end

  assign irqOut = |(flagQ & ienQ);

  // R7: every wrap leaves its flag set on the next clock
  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    |wrapHit |=> ((flagQ & $past(wrapHit)) == $past(wrapHit)));

  // R8: writing 1 to flag A clears it when no wrap of A competes
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr && regWdata[FLAG_LO] && !wrapHit[0] |=> !flagQ[0]);

  // R9: with every enable written to zero the interrupt is quiet
  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr && (regWdata[IEN_LO +: NUM_CNT] == '0) |=> !irqOut);
endmodule

// File: rtl/pm_datapath.sv
module pm_datapath
  import pm_pkg::*;
#(
  parameter int EVT_W    = 64,
  parameter int DIV_LOG2 = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       stb,
  input  logic [EVT_W-1:0]              evtIn,
  output logic [NUM_CNT-1:0][CNT_W-1:0] cntBus,
  output logic [NUM_CNT-1:0]            wrapHit
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int SEL_SPAN = 1 << SEL_W;

  logic [SEL_SPAN-1:0] evPad;
  logic [DIV_LOG2-1:0] preQ;
  logic                cycTick;
  logic                hitA;
  logic                hitB;

  // codes beyond the connected inputs see a constant zero
  assign evPad = {{(SEL_SPAN-EVT_W){1'b0}}, evtIn};
  assign hitA  = (stb.selA == SEL_EVERY_CLK) || evPad[stb.selA];
  assign hitB  = (stb.selB == SEL_EVERY_CLK) || evPad[stb.selB];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            preQ <= '0;
    else if (stb.zeroCyc) preQ <= '0;
    else if (stb.runAll)  preQ <= preQ + 1'b1;
  end

  assign cycTick = stb.runAll && (!stb.divSlow || (preQ == {DIV_LOG2{1'b1}}));

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic bump;
    logic zero;
    if (i == 0) begin : g_a
      assign bump = stb.runAll && hitA;
      assign zero = stb.zeroEvt;
    end else if (i == 1) begin : g_b
      assign bump = stb.runAll && hitB;
      assign zero = stb.zeroEvt;
    end else begin : g_cyc
      assign bump = cycTick;
      assign zero = stb.zeroCyc;
    end

    pm_counter #(.WIDTH(CNT_W)) u_cnt (
      .clk     (clk),
      .rstN    (rstN),
      .load    (stb.loadCnt[i]),
      .loadVal (stb.loadVal),
      .zero    (zero),
      .bump    (bump),
      .count   (cntBus[i]),
      .wrap    (wrapHit[i])
    );

    // R2: stopped, unloaded and unzeroed counters hold their value
    p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
      !stb.runAll && !stb.loadCnt[i] && !zero |=> $stable(cntBus[i]));
  end

  // R5: the shared zeroing bit clears both event counters
  p_zero_pair_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.zeroEvt && stb.loadCnt[1:0] == 2'b00 |=> cntBus[0] == '0 && cntBus[1] == '0);
endmodule

// File: rtl/perf_mon.sv
module perf_mon
  import pm_pkg::*;
#(
  parameter int EVT_W    = 64,
  parameter int DIV_LOG2 = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regSel,
  input  logic             regWr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic [EVT_W-1:0] evtIn,
  output logic             irqOut
);
  timeunit 1ns;
  timeprecision 100ps;

  strobe_t                       stb;
  logic [NUM_CNT-1:0][CNT_W-1:0] cntBus;
  logic [NUM_CNT-1:0]            wrapHit;
  logic [REG_W-1:0]              ctrlRead;

  pm_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regSel   (regSel),
    .regWr    (regWr),
    .regWdata (regWdata),
    .wrapHit  (wrapHit),
    .stb      (stb),
    .ctrlRead (ctrlRead),
    .irqOut   (irqOut)
  );

  pm_datapath #(.EVT_W(EVT_W), .DIV_LOG2(DIV_LOG2)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .evtIn   (evtIn),
    .cntBus  (cntBus),
    .wrapHit (wrapHit)
  );

  always_comb begin
    case (regSel)
      IDX_CTRL: regRdata = ctrlRead;
      IDX_CYC:  regRdata = cntBus[2];
      IDX_A:    regRdata = cntBus[0];
      default:  regRdata = cntBus[1];
    endcase
  end
endmodule

// File: tb/tb_perf_mon.sv
module tb_perf_mon;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int EVT_W = 64;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [1:0]       regSel = '0;
  logic             regWr = 1'b0;
  logic [31:0]      regWdata = '0;
  logic [31:0]      regRdata;
  logic [EVT_W-1:0] evtIn = '0;
  logic             irqOut;

  always #2 clk = ~clk;

  perf_mon #(.EVT_W(EVT_W), .DIV_LOG2(6)) dut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .evtIn(evtIn), .irqOut(irqOut)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    regSel = s;
    #0.2;
    v = regRdata;
  endtask

  // called just after a falling edge; returns just after the next one
  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    regSel = s; regWdata = d; regWr = 1'b1;
    @(posedge clk); @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // ---------------- reference model built from the requirements
  logic [31:0] mCtl, mCyc, mA, mB;
  logic [5:0]  mPre;

  function automatic logic evHit(input logic [7:0] code, input logic [EVT_W-1:0] ev);
    if (code == 8'hFF) return 1'b1;
    if (code < EVT_W) return ev[code[5:0]];
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rstN) begin : model
    logic en, wc, incC, incA, incB, zE, zC, ldC, ldA, ldB, wC, wA, wB;
    logic [2:0] fl;
    if (!rstN) begin
      mCtl = '0; mCyc = '0; mA = '0; mB = '0; mPre = '0;
    end else begin
      en   = mCtl[0];
      wc   = regWr && regSel == 2'd0;
      ldC  = regWr && regSel == 2'd1;
      ldA  = regWr && regSel == 2'd2;
      ldB  = regWr && regSel == 2'd3;
      zE   = wc && regWdata[1];
      zC   = wc && regWdata[2];
      incC = en && (!mCtl[3] || mPre == 6'h3F);
      incA = en && evHit(mCtl[27:20], evtIn);
      incB = en && evHit(mCtl[19:12], evtIn);
      wC   = incC && !ldC && !zC && mCyc == 32'hFFFFFFFF;
      wA   = incA && !ldA && !zE && mA == 32'hFFFFFFFF;
      wB   = incB && !ldB && !zE && mB == 32'hFFFFFFFF;
      mCyc = ldC ? regWdata : zC ? 32'h0 : incC ? mCyc + 1 : mCyc;
      mA   = ldA ? regWdata : zE ? 32'h0 : incA ? mA + 1 : mA;
      mB   = ldB ? regWdata : zE ? 32'h0 : incB ? mB + 1 : mB;
      mPre = zC ? 6'h0 : en ? mPre + 1 : mPre;
      fl   = (mCtl[10:8] & ~(wc ? regWdata[10:8] : 3'b0)) | {wC, wB, wA};
      if (wc) mCtl = regWdata & 32'h0FFFF079;
      mCtl[10:8] = fl;
    end
  end

  function automatic logic [7:0] pickCode();
    case ($urandom % 5)
      0: return 8'hFF;
      1: return 8'h20;
      2: return 8'h64;
      3: return 8'h05;
      default: return 8'($urandom % 64);
    endcase
  endfunction

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin : main
    logic [31:0] v, w;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int i = 0; i < 4; i++) begin rd(2'(i), v); chk("R1 reset reg", v, 32'h0); end
    chk("R1 reset irq", {31'h0, irqOut}, 32'h0);

    // R2 stopped counters hold
    wr(2'd0, 32'h0050_0000);
    wr(2'd2, 32'h10);
    evtIn[5] = 1'b1;
    step(5);
    rd(2'd2, v); chk("R2 stopped counter A", v, 32'h10);
    rd(2'd1, v); chk("R2 stopped cycle", v, 32'h0);

    // R2/R4 run and count selected event
    wr(2'd0, 32'h0050_0001);
    step(4);
    rd(2'd2, v); chk("R4 counter A events", v, 32'h14);
    rd(2'd1, v); chk("R2 cycle runs", v, 32'h4);

    // R4 parked on trace code while low
    wr(2'd0, 32'h0200_0001);
    rd(2'd2, v); step(6); rd(2'd2, w);
    chk("R4 parked code 0x20", w, v);
    // R4 unconnected code with every input high
    wr(2'd0, 32'h0640_0001);
    evtIn = '1;
    rd(2'd2, v); step(6); rd(2'd2, w);
    chk("R4 unconnected code", w, v);
    evtIn = '0; evtIn[5] = 1'b1;

    // R6 load beats increment
    wr(2'd0, 32'h0050_0001);
    wr(2'd2, 32'h1234);
    rd(2'd2, v); chk("R6 load wins", v, 32'h1234);

    // R5 zeroing bits
    wr(2'd3, 32'h55);
    wr(2'd0, 32'h0050_0003);
    rd(2'd2, v); chk("R5 zero A", v, 32'h0);
    rd(2'd3, v); chk("R5 zero B", v, 32'h0);
    rd(2'd0, v); chk("R5 zero bit reads 0", v, 32'h0050_0001);
    wr(2'd0, 32'h0050_0005);
    rd(2'd1, v); chk("R5 zero cycle", v, 32'h0);

    // R3 divide by 64
    wr(2'd0, 32'h0050_000D);
    step(130);
    rd(2'd1, v); chk("R3 divided cycle", v, 32'h2);

    // R7/R9 wrap of counter B on every-clock code
    wr(2'd0, 32'h0050_0001);
    wr(2'd3, 32'hFFFF_FFFE);
    wr(2'd0, 32'h005F_F021);
    rd(2'd3, v); chk("R7 before wrap", v, 32'hFFFF_FFFE);
    step(1);
    rd(2'd3, v); chk("R7 at max", v, 32'hFFFF_FFFF);
    chk("R9 irq before wrap", {31'h0, irqOut}, 32'h0);
    step(1);
    rd(2'd3, v); chk("R7 wrapped", v, 32'h0);
    rd(2'd0, v); chk("R7 flag B set", v, 32'h005F_F221);
    chk("R9 irq raised", {31'h0, irqOut}, 32'h1);

    // R8 write back clears flag only
    wr(2'd0, 32'h005F_F221);
    rd(2'd0, v); chk("R8 write back", v, 32'h005F_F021);
    chk("R9 irq cleared", {31'h0, irqOut}, 32'h0);

    // R8 clear and wrap on one clock
    wr(2'd3, 32'hFFFF_FFFF);
    wr(2'd0, 32'h005F_F221);
    rd(2'd0, v); chk("R8 wrap beats clear", v, 32'h005F_F221);
    chk("R9 irq held", {31'h0, irqOut}, 32'h1);
    rd(2'd3, v); chk("R7 wrap after load", v, 32'h0);

    // R10 reserved bits
    wr(2'd0, 32'hF000_0A80);
    rd(2'd0, v); chk("R10 reserved bits", v, 32'h0);
    rd(2'd2, v); step(5); rd(2'd2, w);
    chk("R2 stopped again", w, v);

    // random phase against the model
    rstN = 1'b0;
    step(2);
    rstN = 1'b1;
    for (int n = 0; n < 4000; n++) begin
      rd(2'd0, v); chk("R8 control", v, mCtl);
      rd(2'd1, v); chk("R3 cycle", v, mCyc);
      rd(2'd2, v); chk("R4 counter A", v, mA);
      rd(2'd3, v); chk("R4 counter B", v, mB);
      chk("R9 irq", {31'h0, irqOut}, {31'h0, |(mCtl[10:8] & mCtl[6:4])});
      evtIn = {$urandom, $urandom};
      if ($urandom % 10 < 2) begin
        regWr = 1'b1;
        regSel = 2'($urandom % 4);
        if (regSel == 2'd0) begin
          v = $urandom;
          v[0] = ($urandom % 8) != 0;
          v[1] = ($urandom % 6) == 0;
          v[2] = ($urandom % 6) == 0;
          v[3] = ($urandom % 4) == 0;
          v[27:20] = pickCode();
          v[19:12] = pickCode();
          regWdata = v;
        end else begin
          regWdata = ($urandom % 2) ? (32'hFFFF_FFF0 | 32'($urandom % 16)) : $urandom;
        end
      end else begin
        regWr = 1'b0;
      end
      @(posedge clk); @(negedge clk);
    end
    regWr = 1'b0;
    done = 1;
    finishRun();
  end
endmodule